// File: doc/BRIEF.md
# Special Register Access Privilege Gate

This block stands between a core's move-to-special-register and move-from-special-register instructions and the register file that holds those registers. On every request it checks that the current status word grants access. It then decides whether the address names a register that may be read or written in the requested direction. The result is a single enable toward the register file, an error pulse with a code, or a fetch redirect.

Read data coming back from the register file is registered and returned one cycle after the request, together with a valid strobe. Refused or faulty reads return zero. Two writes have side effects: a write to the next-PC register causes a fetch redirect to the written value, which also drops any pending delay-slot state. The tick-timer mode register accepts only a zero write.

Top module: `spr_access_gate`

## Requirements
- R1: When `req_valid` is high and both `sr_super` and `sr_user_ok` are low, the block raises `err` with `err_code` = 1 (privilege). It asserts no enable and no redirect, and a refused read returns `rsp_data` = 0.
- R2: With privilege, a read of VER 0x0000, UNITS 0x0001, CFG 0x0002, STAT 0x0011, PPC 0x0012, FPCSR 0x0014, EPC 0x0020, MACLO 0x2801 or MACHI 0x2802 asserts only the matching `rd_en` bit. The bit indices are VER 0, UNITS 1, CFG 2, STAT 3, PPC 4, FPCSR 5, EPC 6, ESR 7, MACLO 8, MACHI 9, NPC 10, TTMR 11. At most one bit of `rd_en` and of `wr_en` is ever high.
- R3: With privilege, any access to the shadow range 0x0400..0x05FF asserts `gpr_rd_en` or `gpr_wr_en` with `gpr_idx` = address − 0x0400. No named enable is asserted and no error is raised.
- R4: With privilege, a write to STAT, FPCSR, EPC, ESR 0x0040, MACLO or MACHI asserts only the matching `wr_en` bit.
- R5: With privilege, any other access raises `err` with `err_code` = 2 (address) and asserts no enable and no redirect. This covers unlisted addresses, reads of ESR, NPC 0x0010 or TTMR 0x5000, and writes to VER, UNITS, CFG or PPC.
- R6: With privilege, a write to NPC 0x0010 asserts `redirect` in the same cycle with `redirect_pc` = `req_wdata`, and asserts no write enable.
- R7: With privilege, a write of zero to TTMR 0x5000 asserts `wr_en[11]` without error. A nonzero write raises `err` with `err_code` = 3 (value) and asserts no enable.
- R8: `err` is combinational with the request, lasting exactly the request's cycle, and is low whenever `req_valid` is low.
- R9: Every read request, accepted or not, gives `rsp_valid` high in the next cycle. `rsp_data` is the `rd_data_in` seen in the request cycle for an accepted read and zero otherwise. A cycle without a read request gives `rsp_valid` low in the next cycle.
- R10: During and after reset, before any request, `rsp_valid` and `rsp_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | ADDR_W (16) | Special register address |
| req_wdata | input | DATA_W (32) | Write data |
| sr_super | input | 1 | Status word supervisor bit |
| sr_user_ok | input | 1 | Status word user-access-allowed bit |
| rd_data_in | input | DATA_W (32) | Data from the register file for the enabled register |
| rd_en | output | 12 | One-hot read enable per named register |
| wr_en | output | 12 | One-hot write enable per named register |
| gpr_rd_en | output | 1 | Shadow register read enable |
| gpr_wr_en | output | 1 | Shadow register write enable |
| gpr_idx | output | IDX_W (9) | Shadow register index |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_data | output | DATA_W (32) | Read response data |
| err | output | 1 | Error pulse with the offending request |
| err_code | output | 2 | 0 none, 1 privilege, 2 address, 3 value |
| redirect | output | 1 | Fetch redirect request |
| redirect_pc | output | DATA_W (32) | Redirect target |

## Verification
A registered read response and the combinational verdict on the next request meet in the same cycle. A read followed at once by a faulty access puts the returning data and an error pulse together, and a read followed at once by a next-PC write puts the data and a redirect together. The bench issues such back-to-back pairs and checks both the late response and the new verdict at the same sample point, against a model that knows which cycle each belongs to. A sweep over every named address, both shadow boundaries, neighbouring addresses and all four privilege-bit combinations in both directions covers the rest.

// File: rtl/spr_gate_pkg.sv
package spr_gate_pkg;

    localparam int NUM_REGS = 12;

    localparam int ID_VER   = 0;
    localparam int ID_UNITS = 1;
    localparam int ID_CFG   = 2;
    localparam int ID_STAT  = 3;
    localparam int ID_PPC   = 4;
    localparam int ID_FPCSR = 5;
    localparam int ID_EPC   = 6;
    localparam int ID_ESR   = 7;
    localparam int ID_MACLO = 8;
    localparam int ID_MACHI = 9;
    localparam int ID_NPC   = 10;
    localparam int ID_TTMR  = 11;

    // Registers readable through the gate, and registers with a plain write.
    localparam logic [NUM_REGS-1:0] RD_MASK = 12'h37F;
    localparam logic [NUM_REGS-1:0] WR_MASK = 12'h3E8;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_PRIV  = 2'd1,
        ERR_ADDR  = 2'd2,
        ERR_VALUE = 2'd3
    } gate_err_e;

    function automatic logic [15:0] reg_addr(input int id);
        case (id)
            ID_VER:   reg_addr = 16'h0000;
            ID_UNITS: reg_addr = 16'h0001;
            ID_CFG:   reg_addr = 16'h0002;
            ID_STAT:  reg_addr = 16'h0011;
            ID_PPC:   reg_addr = 16'h0012;
            ID_FPCSR: reg_addr = 16'h0014;
            ID_EPC:   reg_addr = 16'h0020;
            ID_ESR:   reg_addr = 16'h0040;
            ID_MACLO: reg_addr = 16'h2801;
            ID_MACHI: reg_addr = 16'h2802;
            ID_NPC:   reg_addr = 16'h0010;
            default:  reg_addr = 16'h5000;
        endcase
    endfunction

endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode
    import spr_gate_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SHADOW_BASE = 16'h0400,
    parameter int SHADOW_CNT  = 512,
    localparam int IDX_W      = $clog2(SHADOW_CNT)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit_vec,
    output logic                shadow_hit,
    output logic [IDX_W-1:0]    shadow_idx
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(SHADOW_BASE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(SHADOW_BASE + SHADOW_CNT);

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] offset;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
        assign hit_vec[i] = (addr == ADDR_W'(reg_addr(i)));
    end

    assign addr_x     = {1'b0, addr};
    assign offset     = addr_x - LO;
    assign shadow_hit = (addr_x >= LO) && (addr_x < HI);
    assign shadow_idx = offset[IDX_W-1:0];
endmodule

// File: rtl/spr_priv_check.sv
module spr_priv_check (
    input  logic req_valid,
    input  logic sr_super,
    input  logic sr_user_ok,
    output logic granted,
    output logic refused
);
    assign granted = req_valid && (sr_super || sr_user_ok);
    assign refused = req_valid && !(sr_super || sr_user_ok);
endmodule

// File: rtl/spr_access_gate.sv
module spr_access_gate
    import spr_gate_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SHADOW_BASE = 16'h0400,
    parameter int SHADOW_CNT  = 512,
    localparam int IDX_W      = $clog2(SHADOW_CNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                sr_super,
    input  logic                sr_user_ok,
    input  logic [DATA_W-1:0]   rd_data_in,
    output logic [NUM_REGS-1:0] rd_en,
    output logic [NUM_REGS-1:0] wr_en,
    output logic                gpr_rd_en,
    output logic                gpr_wr_en,
    output logic [IDX_W-1:0]    gpr_idx,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                err,
    output logic [1:0]          err_code,
    output logic                redirect,
    output logic [DATA_W-1:0]   redirect_pc
);
    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } rsp_t;

    rsp_t st_d, st_q;

    logic [NUM_REGS-1:0] hit_vec;
    logic                shadow_hit;
    logic                granted;
    logic                refused;
    gate_err_e           code;

    spr_addr_decode #(
        .ADDR_W      (ADDR_W),
        .SHADOW_BASE (SHADOW_BASE),
        .SHADOW_CNT  (SHADOW_CNT)
    ) u_dec (
        .addr       (req_addr),
        .hit_vec    (hit_vec),
        .shadow_hit (shadow_hit),
        .shadow_idx (gpr_idx)
    );

    spr_priv_check u_priv (
        .req_valid  (req_valid),
        .sr_super   (sr_super),
        .sr_user_ok (sr_user_ok),
        .granted    (granted),
        .refused    (refused)
    );

    always_comb begin
        rd_en         = '0;
        wr_en         = '0;
        gpr_rd_en     = 1'b0;
        gpr_wr_en     = 1'b0;
        redirect      = 1'b0;
        redirect_pc   = req_wdata;
        code          = ERR_NONE;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.rsp_data  = '0;

        if (refused) begin
            code = ERR_PRIV;
        end else if (granted) begin
            if (shadow_hit) begin
                if (req_write) begin
                    gpr_wr_en = 1'b1;
                end else begin
                    gpr_rd_en     = 1'b1;
                    st_d.rsp_data = rd_data_in;
                end
            end else if (!req_write) begin
                if ((hit_vec & RD_MASK) != '0) begin
                    rd_en         = hit_vec;
                    st_d.rsp_data = rd_data_in;
                end else begin
                    code = ERR_ADDR;
                end
            end else if ((hit_vec & WR_MASK) != '0) begin
                wr_en = hit_vec;
            end else if (hit_vec[ID_NPC]) begin
                redirect = 1'b1;
            end else if (hit_vec[ID_TTMR]) begin
                if (req_wdata == '0) begin
                    wr_en = hit_vec;
                end else begin
                    code = ERR_VALUE;
                end
            end else begin
                code = ERR_ADDR;
            end
        end

        err      = (code != ERR_NONE);
        err_code = code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
endmodule

// File: rtl/spr_gate_checker.sv
module spr_gate_checker #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [DATA_W-1:0]   req_wdata,
    input logic                sr_super,
    input logic                sr_user_ok,
    input logic [NUM_REGS-1:0] rd_en,
    input logic [NUM_REGS-1:0] wr_en,
    input logic                gpr_rd_en,
    input logic                gpr_wr_en,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_data,
    input logic                err,
    input logic [1:0]          err_code,
    input logic                redirect,
    input logic [DATA_W-1:0]   redirect_pc
);
    assert_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sr_super && !sr_user_ok) |->
        (err && err_code == 2'd1 && wr_en == '0 && rd_en == '0 && !gpr_wr_en && !redirect));

    assert_refuse_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !sr_super && !sr_user_ok) |=> (rsp_valid && rsp_data == '0));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_en) && $onehot0(wr_en));

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd_en == '0 && wr_en == '0 && !gpr_rd_en && !gpr_wr_en && !redirect));

    assert_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (req_valid && req_write && redirect_pc == req_wdata && wr_en == '0));

    assert_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == 2'd3) |-> (req_write && req_wdata != '0));

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !err);

    assert_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_noresp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind spr_access_gate spr_gate_checker #(
    .DATA_W   (DATA_W),
    .NUM_REGS (spr_gate_pkg::NUM_REGS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .sr_super    (sr_super),
    .sr_user_ok  (sr_user_ok),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .gpr_rd_en   (gpr_rd_en),
    .gpr_wr_en   (gpr_wr_en),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .err         (err),
    .err_code    (err_code),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
);

// File: tb/spr_access_gate_tb.sv
`timescale 1ns/1ps
module spr_access_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        sr_super = 1'b0;
    logic        sr_user_ok = 1'b0;
    logic [31:0] rd_data_in;
    logic [11:0] rd_en, wr_en;
    logic        gpr_rd_en, gpr_wr_en;
    logic [8:0]  gpr_idx;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        err;
    logic [1:0]  err_code;
    logic        redirect;
    logic [31:0] redirect_pc;

    int n_checks = 0;
    int n_fails  = 0;
    logic        exp_rv = 1'b0;
    logic [31:0] exp_rd = '0;

    always #2 clk = ~clk;

    // Register file stand-in: data depends only on the address.
    assign rd_data_in = {req_addr ^ 16'hBEEF, req_addr};

    spr_access_gate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .sr_super(sr_super),
        .sr_user_ok(sr_user_ok), .rd_data_in(rd_data_in), .rd_en(rd_en),
        .wr_en(wr_en), .gpr_rd_en(gpr_rd_en), .gpr_wr_en(gpr_wr_en),
        .gpr_idx(gpr_idx), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .err(err), .err_code(err_code), .redirect(redirect), .redirect_pc(redirect_pc)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int id_of(input logic [15:0] a);
        case (a)
            16'h0000: id_of = 0;  16'h0001: id_of = 1;  16'h0002: id_of = 2;
            16'h0011: id_of = 3;  16'h0012: id_of = 4;  16'h0014: id_of = 5;
            16'h0020: id_of = 6;  16'h0040: id_of = 7;  16'h2801: id_of = 8;
            16'h2802: id_of = 9;  16'h0010: id_of = 10; 16'h5000: id_of = 11;
            default:  id_of = -1;
        endcase
    endfunction

    // One request cycle: check the previous response, drive, check the verdict.
    task automatic step(input logic v, input logic w, input logic [15:0] a,
                        input logic [31:0] d, input logic s, input logic u);
        int          id;
        logic        shadow;
        logic [11:0] e_rd, e_wr;
        logic        e_grd, e_gwr, e_redir;
        logic [1:0]  e_code;
        logic [8:0]  e_idx;
        string       tag;
        @(negedge clk);
        check("R9 response", {31'd0, rsp_valid, rsp_data}, {31'd0, exp_rv, exp_rd});
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        sr_super = s; sr_user_ok = u;
        #1;
        id = id_of(a);
        shadow = (a >= 16'h0400) && (a <= 16'h05FF);
        e_rd = '0; e_wr = '0; e_grd = 0; e_gwr = 0; e_redir = 0; e_code = 0;
        e_idx = 9'(a - 16'h0400);
        tag = "R2 read";
        if (!v) begin
            tag = "R8 idle";
        end else if (!(s || u)) begin
            tag = "R1 privilege"; e_code = 1;
        end else if (shadow) begin
            tag = "R3 shadow";
            if (w) e_gwr = 1; else e_grd = 1;
        end else if (!w) begin
            if (id >= 0 && id != 7 && id != 10 && id != 11) e_rd[id] = 1'b1;
            else begin tag = "R5 address"; e_code = 2; end
        end else if (id == 10) begin
            tag = "R6 redirect"; e_redir = 1;
        end else if (id == 11) begin
            tag = "R7 timer";
            if (d == 0) e_wr[11] = 1'b1; else e_code = 3;
        end else if (id >= 3 && id <= 9 && id != 4) begin
            tag = "R4 write"; e_wr[id] = 1'b1;
        end else begin
            tag = "R5 address"; e_code = 2;
        end
        check(tag, {rd_en, wr_en, gpr_rd_en, gpr_wr_en, redirect, err, err_code},
                   {e_rd, e_wr, e_grd, e_gwr, e_redir, (e_code != 0), e_code});
        if (e_grd || e_gwr) check("R3 index", {55'd0, gpr_idx}, {55'd0, e_idx});
        if (e_redir) check("R6 target", {32'd0, redirect_pc}, {32'd0, d});
        exp_rv = v && !w;
        exp_rd = (e_grd || e_rd != 0) ? {a ^ 16'hBEEF, a} : 32'd0;
    endtask

    initial begin
        #800000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] addrs [22];
        addrs = '{16'h0000, 16'h0001, 16'h0002, 16'h0011, 16'h0012, 16'h0014,
                  16'h0020, 16'h0040, 16'h2801, 16'h2802, 16'h0010, 16'h5000,
                  16'h03FF, 16'h0400, 16'h0401, 16'h05FE, 16'h05FF, 16'h0600,
                  16'h0003, 16'hFFFF, 16'h2800, 16'h5001};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", {31'd0, rsp_valid, rsp_data}, 64'd0);
        rst_n = 1'b1;
        step(0, 0, 16'h0011, 0, 1, 0);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 22; k++) begin
                step(1, 0, addrs[k], 0, p[1], p[0]);
                step(1, 1, addrs[k], 32'd0, p[1], p[0]);
                step(1, 1, addrs[k], 32'h1234_0000 + 32'(k), p[1], p[0]);
                step(0, 0, addrs[k], 0, p[1], p[0]);
            end
        end
        // Back-to-back: read response lands with an error pulse, then with a redirect.
        step(1, 0, 16'h0011, 0, 1, 0);
        step(1, 1, 16'h0000, 32'h5, 1, 0);
        step(1, 0, 16'h0500, 0, 0, 1);
        step(1, 1, 16'h0010, 32'h0000_2000, 0, 1);
        step(1, 0, 16'h2802, 0, 1, 1);
        step(1, 1, 16'h5000, 32'h1, 1, 1);
        step(1, 0, 16'h0012, 0, 0, 0);
        step(1, 0, 16'h0014, 0, 1, 0);
        step(0, 0, 16'h0000, 0, 0, 0);
        step(0, 0, 16'h0000, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule